// File: doc/BRIEF.md
# Indexed Codec Control Register Front End

This block is the host-side register window of an audio codec. A small parallel bus with a two-bit select reaches four byte-wide ports: an index register, a data port, a status register and a playback data register. The index register chooses one of 32 indirect control registers, and the data port then reads or writes that register. The index register also carries a transfer-request-disable bit and a mode-change-enable bit. Its top bit shows whether the codec is still starting up.

After reset the block counts a set number of cycles before it accepts host traffic. While it is starting up, or while the power-mode input selects software power-down, the index and data ports ignore writes and read a fixed byte. The format registers and the interface-configuration register are protected: they change only while mode-change-enable is set, except for two stream-enable bits that may be changed at any time. The block also holds the interrupt flag and the playback-data-ready flag. It masks the playback and capture DMA requests with the interrupt flag, drives the interrupt pin through an enable bit, and mutes the DAC while a mode change is open.

Top module: `codec_host_regs`

## Requirements
- R1: After reset the index port and the data port read 8'h80 for INIT_CYCLES cycles. After that the index port reads 8'h40: bit 7 (start-up flag) is 0, bit 6 (mode-change-enable) is 1, and every other bit is 0.
- R2: While start-up is in progress, or while pwr_mode equals 2'b01, writes to the index port and to the data port are ignored, and both ports read 8'h80.
- R3: Index port layout: bits 4..0 are the indirect index, bit 5 is transfer-request-disable and bit 6 is mode-change-enable. All three fields read back as written. Bit 7 is read-only.
- R4: While compat_mode is 1, index bit 4 is stored as 0 when the index port is written. The data port then reaches only indices 0 to 15, because bit 4 of the stored index is ignored.
- R5: The indirect registers at indices 8, 9 and 28 accept data-port writes only while mode-change-enable is 1. Other indices accept writes at any time.
- R6: At index 9, bit 0 (playback enable) and bit 1 (capture enable) are writable even while mode-change-enable is 0.
- R7: dac_mute is 1 exactly while mode-change-enable is 1.
- R8: While transfer-request-disable is 1 and the interrupt flag is set, pb_drq and cap_drq are 0. Otherwise they follow pb_drq_req and cap_drq_req.
- R9: The status port (select 2) reads the interrupt flag in bit 0, playback-data-ready in bit 1, and 0 in bits 7..2. A pulse on intr_set sets the interrupt flag. Any write to the status port clears it, unless intr_set is high in the same cycle. A status write changes no other state.
- R10: irq equals the interrupt flag ANDed with bit 1 of indirect register 10 (interrupt enable).
- R11: A write to the playback data port (select 3) stores the byte and drops playback-data-ready to 0. A pulse on pb_consume raises it to 1. A read of select 3 returns the stored byte.
- R12: Port selects: 0 is the index port, 1 the data port, 2 the status port and 3 the playback data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Port select (0 index, 1 data, 2 status, 3 playback data) |
| wr_en | input | 1 | Write strobe for the selected port |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected port |
| compat_mode | input | 1 | Restricts the indirect window to 16 registers |
| pwr_mode | input | 2 | Power mode; 2'b01 is software power-down |
| intr_set | input | 1 | Interrupt event from the datapath |
| pb_consume | input | 1 | Playback byte taken by the datapath |
| pb_drq_req | input | 1 | Raw playback DMA request |
| cap_drq_req | input | 1 | Raw capture DMA request |
| pb_drq | output | 1 | Gated playback DMA request |
| cap_drq | output | 1 | Gated capture DMA request |
| irq | output | 1 | Interrupt pin |
| dac_mute | output | 1 | DAC mute |

## Verification
The assertions hold on every cycle for the following rules: blocked index writes leave the index unchanged, compatibility-mode writes clear index bit 4, DMA requests are masked, the interrupt pin stays low while it is not enabled, a status write clears the flag, and a playback write drops the ready flag. The bench scenarios cover what needs a sequence of operations: the start-up count and the 8'h40 value after it, the protected registers and their stream-enable exception, the narrower window in compatibility mode, and read-back through each port.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  typedef enum logic [1:0] {
    SEL_INDEX  = 2'd0,
    SEL_DATA   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_PBDATA = 2'd3
  } port_sel_e;

  localparam int IDX_FMT_A   = 8;
  localparam int IDX_IF_CFG  = 9;
  localparam int IDX_PIN_CTL = 10;
  localparam int IDX_FMT_B   = 28;
  localparam int IEN_BIT     = 1;
  localparam logic [7:0] CFG_FREE_MASK = 8'h03;
  localparam logic [7:0] BLOCKED_READ  = 8'h80;
  localparam logic [6:0] INDEX_RESET   = 7'h40;
  localparam logic [1:0] PM_SOFT_DOWN  = 2'b01;
endpackage

// File: rtl/crg_init_seq.sv
module crg_init_seq #(
  parameter int INIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign busy   = (cnt_q != LIMIT);
  assign cnt_en = busy;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/crg_indirect_file.sv
module crg_indirect_file
  import codec_regs_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic [DW-1:0]           wr_data,
  input  logic                    mce,
  output logic [DW-1:0]           rd_data,
  output logic                    ien
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q, d, mask;
    logic          hit;

    assign hit = wr_en && (idx == AW'(g));

    always_comb begin
      if (g == IDX_FMT_A || g == IDX_FMT_B)
        mask = mce ? '1 : '0;
      else if (g == IDX_IF_CFG)
        mask = mce ? '1 : DW'(CFG_FREE_MASK);
      else
        mask = '1;
      d = hit ? ((q & ~mask) | (wr_data & mask)) : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= d;
    end

    assign regs[g] = q;
  end

  assign rd_data = regs[idx];
  assign ien     = regs[IDX_PIN_CTL][IEN_BIT];
endmodule

// File: rtl/crg_status.sv
module crg_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_set,
  input  logic          int_clr,
  input  logic          pb_load,
  input  logic          pb_consume,
  input  logic [DW-1:0] pb_din,
  output logic          int_q,
  output logic          pb_ready,
  output logic [DW-1:0] pb_sample
);
  logic int_d, full_q, full_d;

  always_comb begin
    int_d = int_q;
    if (int_clr) int_d = 1'b0;
    if (int_set) int_d = 1'b1;
    full_d = full_q;
    if (pb_consume) full_d = 1'b0;
    if (pb_load)    full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      int_q  <= int_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pb_sample <= '0;
    else if (pb_load) pb_sample <= pb_din;
  end

  assign pb_ready = ~full_q;
endmodule

// File: rtl/codec_host_regs.sv
module codec_host_regs
  import codec_regs_pkg::*;
#(
  parameter int INIT_CYCLES = 16,
  parameter int NREG        = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       compat_mode,
  input  logic [1:0] pwr_mode,
  input  logic       intr_set,
  input  logic       pb_consume,
  input  logic       pb_drq_req,
  input  logic       cap_drq_req,
  output logic       pb_drq,
  output logic       cap_drq,
  output logic       irq,
  output logic       dac_mute
);
  localparam int AW = $clog2(NREG);

  logic          rst_meta_q, rst_sync_n;
  logic          busy, blocked;
  logic [6:0]    idx_q, idx_d;
  logic          idx_we, data_we, stat_we, pb_we;
  logic [AW-1:0] eff_idx;
  logic [7:0]    file_rd, pb_sample;
  logic          ien, int_q, pb_ready;
  logic          trd, mce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  crg_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .busy (busy)
  );

  assign blocked = busy || (pwr_mode == PM_SOFT_DOWN);
  assign idx_we  = wr_en && (sel == SEL_INDEX)  && !blocked;
  assign data_we = wr_en && (sel == SEL_DATA)   && !blocked;
  assign stat_we = wr_en && (sel == SEL_STATUS);
  assign pb_we   = wr_en && (sel == SEL_PBDATA);

  always_comb begin
    idx_d = idx_q;
    if (idx_we) begin
      idx_d[6:5] = wr_data[6:5];
      idx_d[4]   = compat_mode ? 1'b0 : wr_data[4];
      idx_d[3:0] = wr_data[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  idx_q <= INDEX_RESET;
    else if (idx_we)  idx_q <= idx_d;
  end

  assign trd = idx_q[5];
  assign mce = idx_q[6];

  always_comb begin
    eff_idx = AW'(idx_q[4:0]);
    if (compat_mode) eff_idx[AW-1] = 1'b0;
  end

  crg_indirect_file #(.NREG(NREG), .DW(8)) u_file (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (data_we),
    .idx    (eff_idx),
    .wr_data(wr_data),
    .mce    (mce),
    .rd_data(file_rd),
    .ien    (ien)
  );

  crg_status #(.DW(8)) u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .int_set   (intr_set),
    .int_clr   (stat_we),
    .pb_load   (pb_we),
    .pb_consume(pb_consume),
    .pb_din    (wr_data),
    .int_q     (int_q),
    .pb_ready  (pb_ready),
    .pb_sample (pb_sample)
  );

  always_comb begin
    unique case (sel)
      SEL_INDEX:  rd_data = blocked ? BLOCKED_READ : {1'b0, idx_q};
      SEL_DATA:   rd_data = blocked ? BLOCKED_READ : file_rd;
      SEL_STATUS: rd_data = {6'b0, pb_ready, int_q};
      default:    rd_data = pb_sample;
    endcase
  end

  assign pb_drq   = pb_drq_req  && !(trd && int_q);
  assign cap_drq  = cap_drq_req && !(trd && int_q);
  assign irq      = int_q && ien;
  assign dac_mute = mce;
endmodule

// File: rtl/codec_host_regs_chk.sv
module codec_host_regs_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [1:0] sel,
  input logic       wr_en,
  input logic       compat_mode,
  input logic       blocked,
  input logic       intr_set,
  input logic [6:0] idx_q,
  input logic       int_q,
  input logic       ien,
  input logic       pb_ready,
  input logic       pb_consume,
  input logic       pb_drq,
  input logic       cap_drq,
  input logic       irq
);
  a_r2_blocked_index_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && sel == 2'd0 && blocked) |=> $stable(idx_q));

  a_r4_compat_clears_bit4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && sel == 2'd0 && !blocked && compat_mode) |=> !idx_q[4]);

  a_r8_drq_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (idx_q[5] && int_q) |-> (!pb_drq && !cap_drq));

  a_r9_status_write_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && sel == 2'd2 && !intr_set) |=> !int_q);

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ien |-> !irq);

  a_r11_pb_write_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && sel == 2'd3) |=> !pb_ready);

  a_r11_consume_ready: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pb_consume && !(wr_en && sel == 2'd3)) |=> pb_ready);
endmodule

bind codec_host_regs codec_host_regs_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sel        (sel),
  .wr_en      (wr_en),
  .compat_mode(compat_mode),
  .blocked    (blocked),
  .intr_set   (intr_set),
  .idx_q      (idx_q),
  .int_q      (int_q),
  .ien        (ien),
  .pb_ready   (pb_ready),
  .pb_consume (pb_consume),
  .pb_drq     (pb_drq),
  .cap_drq    (cap_drq),
  .irq        (irq)
);

// File: tb/codec_host_regs_bench.sv
module codec_host_regs_bench;
  localparam int INIT_CYCLES = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       compat_mode;
  logic [1:0] pwr_mode;
  logic       intr_set, pb_consume, pb_drq_req, cap_drq_req;
  logic       pb_drq, cap_drq, irq, dac_mute;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  codec_host_regs #(.INIT_CYCLES(INIT_CYCLES)) u_codec_host_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .compat_mode(compat_mode), .pwr_mode(pwr_mode),
    .intr_set(intr_set), .pb_consume(pb_consume), .pb_drq_req(pb_drq_req),
    .cap_drq_req(cap_drq_req), .pb_drq(pb_drq), .cap_drq(cap_drq),
    .irq(irq), .dac_mute(dac_mute)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    sel = s;
    #1 d = rd_data;
  endtask

  task automatic pulse_int();
    @(negedge clk); intr_set = 1'b1;
    @(negedge clk); intr_set = 1'b0;
  endtask

  task automatic t_reset_init();
    logic [7:0] v;
    rd(2'd0, v); check("R1 index during start-up", v, 8'h80);
    rd(2'd1, v); check("R1 data during start-up", v, 8'h80);
    wr(2'd0, 8'h05);
    repeat (INIT_CYCLES + 4) @(negedge clk);
    rd(2'd0, v); check("R1 R2 index after start-up", v, 8'h40);
    check("R7 mute after start-up", {7'b0, dac_mute}, 8'h01);
  endtask

  task automatic t_index_fields();
    logic [7:0] v;
    wr(2'd0, 8'h3F); rd(2'd0, v); check("R3 fields readback", v, 8'h3F);
    check("R7 mute off", {7'b0, dac_mute}, 8'h00);
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R3 bit7 read-only", v, 8'h7F);
    check("R7 mute on", {7'b0, dac_mute}, 8'h01);
    rd(2'd2, v); check("R12 status select", v, 8'h02);
  endtask

  task automatic t_protect();
    logic [7:0] v;
    wr(2'd0, 8'h48); wr(2'd1, 8'hA5); rd(2'd1, v); check("R5 fmt write open", v, 8'hA5);
    wr(2'd0, 8'h08); wr(2'd1, 8'h11); rd(2'd1, v); check("R5 fmt write closed", v, 8'hA5);
    wr(2'd0, 8'h09); wr(2'd1, 8'hFF); rd(2'd1, v); check("R6 cfg enables only", v, 8'h03);
    wr(2'd1, 8'h00); rd(2'd1, v); check("R6 cfg enables clear", v, 8'h00);
    wr(2'd0, 8'h1C); wr(2'd1, 8'h77); rd(2'd1, v); check("R5 fmt2 closed", v, 8'h00);
    wr(2'd0, 8'h5C); wr(2'd1, 8'h77); rd(2'd1, v); check("R5 fmt2 open", v, 8'h77);
    wr(2'd0, 8'h03); wr(2'd1, 8'h9A); rd(2'd1, v); check("R5 plain reg", v, 8'h9A);
  endtask

  task automatic t_compat();
    logic [7:0] v;
    wr(2'd0, 8'h53); wr(2'd1, 8'hC3);
    @(negedge clk); compat_mode = 1'b1;
    rd(2'd0, v); check("R4 stored bit4 kept", v, 8'h53);
    rd(2'd1, v); check("R4 window reaches 3", v, 8'h9A);
    wr(2'd0, 8'h5F); rd(2'd0, v); check("R4 bit4 cleared", v, 8'h4F);
    @(negedge clk); compat_mode = 1'b0;
    wr(2'd0, 8'h53); rd(2'd1, v); check("R4 full window 19", v, 8'hC3);
  endtask

  task automatic t_drq_irq();
    logic [7:0] v;
    @(negedge clk); pb_drq_req = 1'b1; cap_drq_req = 1'b1;
    wr(2'd0, 8'h40); pulse_int();
    #1 check("R8 unmasked", {6'b0, pb_drq, cap_drq}, 8'h03);
    check("R10 irq disabled", {7'b0, irq}, 8'h00);
    wr(2'd0, 8'h60);
    #1 check("R8 masked", {6'b0, pb_drq, cap_drq}, 8'h00);
    wr(2'd0, 8'h6A); wr(2'd1, 8'h02);
    #1 check("R10 irq enabled", {7'b0, irq}, 8'h01);
    rd(2'd2, v); check("R9 status int", v, 8'h03);
    wr(2'd2, 8'h00);
    #1 check("R9 R10 clear", {6'b0, irq, pb_drq}, 8'h01);
    rd(2'd0, v); check("R9 index untouched", v, 8'h6A);
    @(negedge clk); sel = 2'd2; wr_data = 8'hFF; wr_en = 1'b1; intr_set = 1'b1;
    @(negedge clk); wr_en = 1'b0; intr_set = 1'b0;
    rd(2'd2, v); check("R9 set wins", v, 8'h03);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_playback();
    logic [7:0] v;
    wr(2'd3, 8'h5A); rd(2'd2, v); check("R11 ready low", v, 8'h00);
    rd(2'd3, v); check("R11 sample readback", v, 8'h5A);
    @(negedge clk); pb_consume = 1'b1;
    @(negedge clk); pb_consume = 1'b0;
    rd(2'd2, v); check("R11 ready high", v, 8'h02);
  endtask

  task automatic t_powerdown();
    logic [7:0] v;
    wr(2'd0, 8'h43);
    @(negedge clk); pwr_mode = 2'b01;
    rd(2'd0, v); check("R2 pd index read", v, 8'h80);
    rd(2'd1, v); check("R2 pd data read", v, 8'h80);
    wr(2'd0, 8'h2F); wr(2'd1, 8'h00);
    @(negedge clk); pwr_mode = 2'b00;
    rd(2'd0, v); check("R2 pd index kept", v, 8'h43);
    rd(2'd1, v); check("R2 pd data kept", v, 8'h9A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 2'd0; wr_en = 1'b0; wr_data = 8'h00;
    compat_mode = 1'b0; pwr_mode = 2'b00; intr_set = 1'b0;
    pb_consume = 1'b0; pb_drq_req = 1'b0; cap_drq_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_init();
    t_index_fields();
    t_protect();
    t_compat();
    t_drq_irq();
    t_playback();
    t_powerdown();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule